// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

The block drives several independent pulse-width-modulated outputs from one source clock. Each channel holds a prescaler setting (stretch), a period length in steps (span), a high length in steps (high), a run bit and two 16-bit pattern words, all reached through a small memory-mapped register bus. One counter step lasts stretch+1 source-clock cycles. A period therefore lasts (stretch+1)×span cycles, and its leading high part lasts (stretch+1)×high cycles.

Software changes a waveform in two phases. Writes to span and high go to staging storage and have no visible effect. A write to stretch captures the staged span and high together with the new stretch as one pending set. A stopped channel adopts that set on the next clock. A running channel adopts it at its next period boundary, so the period in progress always finishes with its old settings. Readback always shows the committed (live) values.

Top module: `scpwm_bank`

## Requirements
- R1: Each channel c owns registers at byte address c×0x20 plus an offset: stretch 0x00, span 0x04, high 0x08, run 0x0C (bit 0), pattern-low 0x10, pattern-high 0x14. Data sits in bits 15:0 and is zero-extended on read. Read data is combinational from the address. Unmapped offsets read 0 and ignore writes. Channels share no state.
- R2: While a channel runs with span ≥ 1, its output repeats with a period of (stretch+1)×span clock cycles.
- R3: Each period starts high and stays high for (stretch+1)×high cycles. The first period starts on the cycle after the run bit is written to 1.
- R4: Writing span or high changes neither the output nor the readback of span or high until stretch is written.
- R5: While a channel is stopped, a stretch write commits stretch together with the staged span and high, and readback shows them from the next cycle on.
- R6: While a channel is running, a committed set takes effect only at the end of the current period, when the next period begins.
- R7: With span = 0 the output stays low. With high ≥ span ≥ 1 the output stays high for the whole period.
- R8: A stopped channel drives its output low. Its prescale and step counters are zero from the second cycle after it stops, so every start begins a fresh period.
- R9: Pattern-low and pattern-high store 16 bits each, read back what was written, and do not affect the output.
- R10: After reset, every register reads 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | AW (8) | Byte address: channel in the upper bits, register offset in the low CH_SH bits |
| bus_wdata | input | BW (32) | Write data |
| bus_rdata | output | BW (32) | Read data for bus_addr, zero-extended |
| pwm_out | output | NUM_CH (4) | One PWM output per channel |

## Verification
The hardest case to reach is a commit racing a running period. The pending set has to arrive partway through a period, possibly while the output is high, and then wait out the remaining steps of the old period. The stimulus configures a channel, starts it and measures one full period. It then writes new span, high and stretch values at an arbitrary point in the next period, while the bus address stays on the span register. The reference model compares the readback and the output on every clock, which pins down the exact switch-over cycle. A later measurement confirms that the new period and high lengths are in force.

// File: rtl/scpwm_pkg.sv
package scpwm_pkg;

   // Register offsets inside one channel window; software decodes these.
   localparam logic [7:0] OFF_STRETCH = 8'h00;
   localparam logic [7:0] OFF_SPAN    = 8'h04;
   localparam logic [7:0] OFF_HIGH    = 8'h08;
   localparam logic [7:0] OFF_RUN     = 8'h0C;
   localparam logic [7:0] OFF_PATLO   = 8'h10;
   localparam logic [7:0] OFF_PATHI   = 8'h14;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STRETCH,
      SEL_SPAN,
      SEL_HIGH,
      SEL_RUN,
      SEL_PATLO,
      SEL_PATHI
   } reg_sel_e;

   function automatic reg_sel_e sel_of(logic [7:0] off);
      case (off)
         OFF_STRETCH: return SEL_STRETCH;
         OFF_SPAN:    return SEL_SPAN;
         OFF_HIGH:    return SEL_HIGH;
         OFF_RUN:     return SEL_RUN;
         OFF_PATLO:   return SEL_PATLO;
         OFF_PATHI:   return SEL_PATHI;
         default:     return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/scpwm_decode.sv
module scpwm_decode
   import scpwm_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned AW     = 8,
   parameter int unsigned CH_SH  = 5
) (
   input  logic [AW-1:0]     addr,
   output logic [NUM_CH-1:0] ch_hit,
   output reg_sel_e          sel
);

   localparam int unsigned CIW = AW - CH_SH;

   logic [CIW-1:0] ch_idx;
   logic [7:0]     off8;

   assign ch_idx = addr[AW-1:CH_SH];
   assign off8   = 8'(addr[CH_SH-1:0]);
   assign sel    = sel_of(off8);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
      assign ch_hit[i] = (ch_idx == CIW'(i));
   end

endmodule

// File: rtl/scpwm_chan_regs.sv
module scpwm_chan_regs
   import scpwm_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_hit,
   input  reg_sel_e      sel,
   input  logic [DW-1:0] wdata,
   input  logic          boundary,
   output logic          run,
   output logic [DW-1:0] act_stretch,
   output logic [DW-1:0] act_span,
   output logic [DW-1:0] act_high,
   output logic [DW-1:0] pat_lo,
   output logic [DW-1:0] pat_hi
);

   logic [DW-1:0] stage_span, stage_high;
   logic [DW-1:0] pend_stretch, pend_span, pend_high;
   logic          pend;
   logic          commit;

   // A pending set lands at once when stopped, else at the period end.
   assign commit = pend && (!run || boundary);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_span   <= '0;
         stage_high   <= '0;
         pend_stretch <= '0;
         pend_span    <= '0;
         pend_high    <= '0;
         pend         <= 1'b0;
         act_stretch  <= '0;
         act_span     <= '0;
         act_high     <= '0;
         run          <= 1'b0;
         pat_lo       <= '0;
         pat_hi       <= '0;
      end else begin
         if (commit) begin
            act_stretch <= pend_stretch;
            act_span    <= pend_span;
            act_high    <= pend_high;
            pend        <= 1'b0;
         end
         if (wr_hit) begin
            case (sel)
               SEL_STRETCH: begin
                  pend_stretch <= wdata;
                  pend_span    <= stage_span;
                  pend_high    <= stage_high;
                  pend         <= 1'b1;
               end
               SEL_SPAN:  stage_span <= wdata;
               SEL_HIGH:  stage_high <= wdata;
               SEL_RUN:   run        <= wdata[0];
               SEL_PATLO: pat_lo     <= wdata;
               SEL_PATHI: pat_hi     <= wdata;
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/scpwm_chan_timer.sv
module scpwm_chan_timer #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [DW-1:0] act_stretch,
   input  logic [DW-1:0] act_span,
   input  logic [DW-1:0] act_high,
   output logic          boundary,
   output logic          out,
   output logic [DW-1:0] pcnt,
   output logic [DW-1:0] scnt
);

   logic last_pre, last_step;

   assign last_pre  = (pcnt == act_stretch);
   assign last_step = (act_span == '0) || (scnt == DW'(act_span - 1'b1));
   assign boundary  = run && last_pre && last_step;
   assign out       = run && (act_span != '0) && (scnt < act_high);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         pcnt <= '0;
         scnt <= '0;
      end else if (last_pre) begin
         pcnt <= '0;
         scnt <= last_step ? '0 : DW'(scnt + 1'b1);
      end else begin
         pcnt <= DW'(pcnt + 1'b1);
      end
   end

endmodule

// File: rtl/scpwm_bank.sv
module scpwm_bank
   import scpwm_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DW     = 16,
   parameter int unsigned BW     = 32,
   parameter int unsigned AW     = 8,
   parameter int unsigned CH_SH  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [AW-1:0]     bus_addr,
   input  logic [BW-1:0]     bus_wdata,
   output logic [BW-1:0]     bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);

   if (DW < 2 || DW > BW) begin : g_bad_dw
      $error("scpwm_bank: DW must lie in 2..BW");
   end
   if (CH_SH < 5 || CH_SH > 8) begin : g_bad_sh
      $error("scpwm_bank: CH_SH must lie in 5..8");
   end
   if (AW <= CH_SH || NUM_CH < 1 || NUM_CH > (1 << (AW - CH_SH))) begin : g_bad_ch
      $error("scpwm_bank: address space too small for NUM_CH");
   end

   logic [NUM_CH-1:0]         ch_hit;
   reg_sel_e                  sel;
   logic [NUM_CH-1:0]         run_v, bnd_v;
   logic [NUM_CH-1:0][DW-1:0] stretch_a, span_a, high_a, pcnt_a, scnt_a;
   logic [NUM_CH-1:0][DW-1:0] patlo_a, pathi_a;
   logic [NUM_CH-1:0][BW-1:0] rd_v;

   scpwm_decode #(.NUM_CH(NUM_CH), .AW(AW), .CH_SH(CH_SH)) u_dec (
      .addr   (bus_addr),
      .ch_hit (ch_hit),
      .sel    (sel)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      scpwm_chan_regs #(.DW(DW)) u_regs (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_hit      (bus_wr && ch_hit[i]),
         .sel         (sel),
         .wdata       (bus_wdata[DW-1:0]),
         .boundary    (bnd_v[i]),
         .run         (run_v[i]),
         .act_stretch (stretch_a[i]),
         .act_span    (span_a[i]),
         .act_high    (high_a[i]),
         .pat_lo      (patlo_a[i]),
         .pat_hi      (pathi_a[i])
      );

      scpwm_chan_timer #(.DW(DW)) u_tmr (
         .clk         (clk),
         .rst_n       (rst_n),
         .run         (run_v[i]),
         .act_stretch (stretch_a[i]),
         .act_span    (span_a[i]),
         .act_high    (high_a[i]),
         .boundary    (bnd_v[i]),
         .out         (pwm_out[i]),
         .pcnt        (pcnt_a[i]),
         .scnt        (scnt_a[i])
      );

      always_comb begin
         case (sel)
            SEL_STRETCH: rd_v[i] = BW'(stretch_a[i]);
            SEL_SPAN:    rd_v[i] = BW'(span_a[i]);
            SEL_HIGH:    rd_v[i] = BW'(high_a[i]);
            SEL_RUN:     rd_v[i] = BW'(run_v[i]);
            SEL_PATLO:   rd_v[i] = BW'(patlo_a[i]);
            SEL_PATHI:   rd_v[i] = BW'(pathi_a[i]);
            default:     rd_v[i] = '0;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_hit[i]) bus_rdata = rd_v[i];
      end
   end

endmodule

// File: rtl/scpwm_bank_chk.sv
module scpwm_bank_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DW     = 16
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_CH-1:0]         run_v,
   input logic [NUM_CH-1:0]         bnd_v,
   input logic [NUM_CH-1:0]         out_v,
   input logic [NUM_CH-1:0][DW-1:0] stretch_a,
   input logic [NUM_CH-1:0][DW-1:0] span_a,
   input logic [NUM_CH-1:0][DW-1:0] high_a,
   input logic [NUM_CH-1:0][DW-1:0] pcnt_a,
   input logic [NUM_CH-1:0][DW-1:0] scnt_a
);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         !run_v[i] |-> !out_v[i]); // R8
      AST_STOPPED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_v[i] && $past(!run_v[i])) |-> (pcnt_a[i] == '0 && scnt_a[i] == '0)); // R8
      AST_ZERO_SPAN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (span_a[i] == '0) |-> !out_v[i]); // R7
      AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         (run_v[i] && span_a[i] != '0 && high_a[i] >= span_a[i]) |-> out_v[i]); // R7
      AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
         (run_v[i] && $past(run_v[i]) && !$past(bnd_v[i]))
            |-> ($stable(span_a[i]) && $stable(high_a[i]) && $stable(stretch_a[i]))); // R6
      AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         (span_a[i] != '0) |-> (scnt_a[i] < span_a[i])); // R2
      AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         run_v[i] |-> (pcnt_a[i] <= stretch_a[i])); // R2
   end

endmodule

bind scpwm_bank scpwm_bank_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_v     (run_v),
   .bnd_v     (bnd_v),
   .out_v     (pwm_out),
   .stretch_a (stretch_a),
   .span_a    (span_a),
   .high_a    (high_a),
   .pcnt_a    (pcnt_a),
   .scnt_a    (scnt_a)
);

// File: tb/scpwm_bank_bench.sv
`timescale 1ns/1ps
module scpwm_bank_bench;

   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   scpwm_bank u_scpwm_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   // ---------------- behavioural reference model ----------------
   int m_stg_s[NCH], m_stg_h[NCH];
   int m_pd[NCH], m_pd_p[NCH], m_pd_s[NCH], m_pd_h[NCH];
   int m_p[NCH], m_s[NCH], m_h[NCH];
   int m_run[NCH], m_pl[NCH], m_ph[NCH];
   int m_pc[NCH], m_sc[NCH];

   function automatic int exp_out(int c);
      return (m_run[c] != 0 && m_s[c] != 0 && m_sc[c] < m_h[c]) ? 1 : 0;
   endfunction

   function automatic int exp_rd(logic [7:0] a);
      int c;
      c = int'(a[7:5]);
      if (c >= NCH) return 0;
      case (a[4:0])
         5'h00: return m_p[c];
         5'h04: return m_s[c];
         5'h08: return m_h[c];
         5'h0C: return m_run[c];
         5'h10: return m_pl[c];
         5'h14: return m_ph[c];
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_stg_s[c] = 0; m_stg_h[c] = 0; m_pd[c] = 0; m_pd_p[c] = 0;
            m_pd_s[c] = 0; m_pd_h[c] = 0; m_p[c] = 0; m_s[c] = 0; m_h[c] = 0;
            m_run[c] = 0; m_pl[c] = 0; m_ph[c] = 0; m_pc[c] = 0; m_sc[c] = 0;
         end
      end else begin
         for (int c = 0; c < NCH; c++) begin
            bit wrap, endp, cm;
            wrap = (m_pc[c] == m_p[c]);
            endp = wrap && (m_s[c] == 0 || m_sc[c] == m_s[c] - 1);
            cm   = (m_pd[c] != 0) && (m_run[c] == 0 || endp);
            if (m_run[c] == 0) begin
               m_pc[c] = 0; m_sc[c] = 0;
            end else if (wrap) begin
               m_pc[c] = 0;
               m_sc[c] = endp ? 0 : m_sc[c] + 1;
            end else begin
               m_pc[c] = m_pc[c] + 1;
            end
            if (cm) begin
               m_p[c] = m_pd_p[c]; m_s[c] = m_pd_s[c]; m_h[c] = m_pd_h[c]; m_pd[c] = 0;
            end
         end
         if (bus_wr && int'(bus_addr[7:5]) < NCH) begin
            int c;
            int d;
            c = int'(bus_addr[7:5]);
            d = int'(bus_wdata[15:0]);
            case (bus_addr[4:0])
               5'h00: begin
                  m_pd_p[c] = d; m_pd_s[c] = m_stg_s[c]; m_pd_h[c] = m_stg_h[c]; m_pd[c] = 1;
               end
               5'h04: m_stg_s[c] = d;
               5'h08: m_stg_h[c] = d;
               5'h0C: m_run[c] = d & 1;
               5'h10: m_pl[c] = d;
               5'h14: m_ph[c] = d;
               default: ;
            endcase
         end
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int c = 0; c < NCH; c++) begin
            checks++;
            if (int'(pwm_out[c]) != exp_out(c)) begin
               fails++;
               $display("FAIL R2/R3/R6/R7/R8 ch%0d pwm_out actual=%0d expected=%0d",
                        c, pwm_out[c], exp_out(c));
            end
         end
         checks++;
         if (bus_rdata != 32'(exp_rd(bus_addr))) begin
            fails++;
            $display("FAIL R1/R4/R5 rdata @%02h actual=%0h expected=%0h",
                     bus_addr, bus_rdata, exp_rd(bus_addr));
         end
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic chk(bit ok, string tag, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic wr(int c, int off, int d);
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_addr = 8'(c * 32 + off); bus_wdata = 32'(d);
      @(negedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(int c, int off, int exp, string tag);
      bus_addr = 8'(c * 32 + off);
      @(negedge clk);
      chk(bus_rdata == 32'(exp), tag, "readback", bus_rdata, exp);
      #1;
   endtask

   task automatic measure(int c, int ehi, int eper, string tag);
      int hi = 0, lo = 0, g = 0;
      while (pwm_out[c] !== 1'b0 && g < 3000) begin @(negedge clk); g++; end
      while (pwm_out[c] !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
      while (pwm_out[c] === 1'b1 && g < 3000) begin hi++; @(negedge clk); g++; end
      while (pwm_out[c] === 1'b0 && g < 3000) begin lo++; @(negedge clk); g++; end
      chk(hi == ehi, tag, "high length", hi, ehi);
      chk(hi + lo == eper, tag, "period length", hi + lo, eper);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #1;
      // R10: reset state
      chk(pwm_out == 4'b0, "R10", "outputs after reset", pwm_out, 0);
      rd(0, 'h00, 0, "R10");
      rd(3, 'h08, 0, "R10");
      rd(2, 'h0C, 0, "R10");

      // R4 / R5: staging while stopped
      wr(0, 'h04, 5);
      wr(0, 'h08, 2);
      rd(0, 'h04, 0, "R4");
      rd(0, 'h08, 0, "R4");
      wr(0, 'h00, 1);
      rd(0, 'h04, 5, "R5");
      rd(0, 'h08, 2, "R5");
      rd(0, 'h00, 1, "R5");

      // R3: output rises on the cycle after the run write
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h1;
      @(negedge clk);
      chk(pwm_out[0] == 1'b1, "R3", "first cycle after start", pwm_out[0], 1);
      #1 bus_wr = 1'b0;
      rd(0, 'h0C, 1, "R1");

      // R2 / R3: period 2*5 = 10, high 2*2 = 4
      measure(0, 4, 10, "R2");

      // R7: full-high and zero-span channels
      wr(1, 'h04, 3); wr(1, 'h08, 3); wr(1, 'h00, 0); wr(1, 'h0C, 1);
      wr(2, 'h04, 0); wr(2, 'h08, 4); wr(2, 'h00, 2); wr(2, 'h0C, 1);
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         chk(pwm_out[1] == 1'b1, "R7", "high>=span level", pwm_out[1], 1);
         chk(pwm_out[2] == 1'b0, "R7", "span=0 level", pwm_out[2], 0);
      end
      #1;

      // R4: high write alone while running does nothing visible
      wr(0, 'h08, 7);
      rd(0, 'h08, 2, "R4");
      measure(0, 4, 10, "R4");

      // R6: running update, switch at the period end (model compares each cycle)
      wr(0, 'h04, 8);
      wr(0, 'h08, 1);
      wr(0, 'h00, 2);
      bus_addr = 8'h04;
      repeat (14) @(negedge clk);
      #1;
      rd(0, 'h04, 8, "R6");
      measure(0, 3, 24, "R6");
      measure(0, 3, 24, "R2");

      // R9: pattern words on a stopped channel
      wr(3, 'h10, 'hA5C3);
      wr(3, 'h14, 'h1_FFFF);
      rd(3, 'h10, 'hA5C3, "R9");
      rd(3, 'h14, 'hFFFF, "R9");
      chk(pwm_out[3] == 1'b0, "R9", "pattern leaves output", pwm_out[3], 0);

      // R1: unmapped offset reads 0 and ignores writes
      wr(1, 'h18, 'h1234);
      rd(1, 'h18, 0, "R1");
      rd(1, 'h04, 3, "R1");

      // R8: stop, output low, restart begins a fresh period
      wr(0, 'h0C, 0);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk(pwm_out[0] == 1'b0, "R8", "stopped output", pwm_out[0], 0);
      end
      #1;
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h1;
      @(negedge clk); #1 bus_wr = 1'b0;
      repeat (2) @(negedge clk);
      chk(pwm_out[0] == 1'b1, "R8", "restart high for 3 cycles", pwm_out[0], 1);
      @(negedge clk);
      chk(pwm_out[0] == 1'b0, "R8", "restart low after high", pwm_out[0], 0);
      #1;
      measure(0, 3, 24, "R8");

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule